// File: doc/BRIEF.md
# Reset-Aware Program Bank Select Controller

This block owns a two-bit program-mapping register. Bit 0 chooses which of two physical memory blocks answers instruction fetches in the low 8 KB of the logical program space. Bit 1 records whether the last warm restart was requested by software. The register's value after a reset depends on two things: which kind of reset occurred, and the state of a non-volatile start-up configuration bit. That bit reads 1 when unprogrammed and 0 when programmed.

Once the part is running, software may rewrite bit 0 to swap the low window between blocks. The controller turns the current logical fetch address and bit 0 into a physical bank select. Remapping the window while code runs inside it is hazardous, so the block raises a sticky error flag when bit 0 is written while the fetch address lies in that window.

All reset causes are synchronous, active-high requests sampled on the clock edge.

Top module: `prog_bank_ctrl`

## Requirements
- R1: On a clock edge with `porRst` high, `mapReg` becomes 2'b00 if `cfgStartN` is 1 and 2'b01 if `cfgStartN` is 0.
- R2: On an edge with `wdtRst` high and `porRst` low, `mapReg[1]` keeps its previous value and `mapReg[0]` becomes the inverse of `cfgStartN`.
- R3: On an edge with `swRst` high and the other two causes low, `mapReg[1]` becomes 1 and `mapReg[0]` becomes the inverse of `cfgStartN`.
- R4: When several causes are high together, `porRst` wins over `wdtRst`, and `wdtRst` wins over `swRst`.
- R5: With no reset cause high, `wrEn` high loads `wrBit` into `mapReg[0]` at the next edge and leaves `mapReg[1]` unchanged.
- R6: While `fetchAddr` is below 16'h2000, `bankSel` equals `mapReg[0]`. This includes the boundary 16'h1FFF.
- R7: While `fetchAddr` is 16'h2000 or above, `bankSel` is 0 whatever `mapReg[0]` holds.
- R8: A write (R5) while `fetchAddr` is below 16'h2000 sets `errFlag` at the next edge. The flag then stays set until a reset.
- R9: A write while `fetchAddr` is 16'h2000 or above does not set `errFlag`.
- R10: Any reset cause clears `errFlag` at the next edge.
- R11: A change of `cfgStartN` with no reset cause high has no effect on `mapReg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on or external reset request |
| wdtRst | input | 1 | Watchdog or brown-out reset request |
| swRst | input | 1 | Software reset request |
| cfgStartN | input | 1 | Non-volatile start-up bit, 1 = unprogrammed |
| wrEn | input | 1 | Software write strobe for mapping bit 0 |
| wrBit | input | 1 | Value written to mapping bit 0 |
| fetchAddr | input | 16 | Logical instruction fetch address |
| mapReg | output | 2 | Mapping register value |
| bankSel | output | 1 | Physical block select for the current fetch |
| errFlag | output | 1 | Sticky flag: remap written inside the low window |

## Verification
The bench targets warm resets in both states of bit 1. A design that reloaded bit 1 on a watchdog reset would show 0 where 1 was kept.

It drives all three causes together and also the watchdog and software causes as a pair. A wrong priority order would load the software pattern, setting bit 1.

Fetch addresses 16'h1FFF and 16'h2000 probe the window edge. An off-by-one decode would flip `bankSel` at one of those two addresses.

Writes inside and outside the window, followed by idle cycles and warm resets, show whether the error flag is sticky, whether it is raised wrongly on outside writes, and whether resets clear it.

// File: rtl/prog_bank_pkg.sv
package prog_bank_pkg;
  // Strobes from the control to the datapath, one action per cycle at most
  typedef struct packed {
    logic loadCold;  // power-on / external load
    logic loadWarm;  // watchdog / brown-out load
    logic loadSoft;  // software-reset load
    logic wrBit0;    // software write to bit 0
    logic setErr;    // write seen inside the low window
  } ctrlStrobes_t;
endpackage

// File: rtl/prog_bank_ctrl_fsm.sv
module prog_bank_ctrl_fsm
  import prog_bank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 13
) (
  input  logic              porRst,
  input  logic              wdtRst,
  input  logic              swRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              inWindow,
  output ctrlStrobes_t      strobes
);
  localparam int HI_W = ADDR_W - WIN_LOG2;

  generate
    if (HI_W > 0) begin : g_win
      assign inWindow = (fetchAddr[ADDR_W-1:WIN_LOG2] == '0);
    end else begin : g_full
      assign inWindow = 1'b1;
    end
  endgenerate

  logic anyRst;
  assign anyRst = porRst | wdtRst | swRst;

  always_comb begin
    strobes          = '0;
    strobes.loadCold = porRst;
    strobes.loadWarm = !porRst && wdtRst;
    strobes.loadSoft = !porRst && !wdtRst && swRst;
    strobes.wrBit0   = !anyRst && wrEn;
    strobes.setErr   = !anyRst && wrEn && inWindow;
  end
endmodule

// File: rtl/prog_bank_datapath.sv
module prog_bank_datapath
  import prog_bank_pkg::*;
(
  input  logic         clk,
  input  logic         porRst,
  input  ctrlStrobes_t strobes,
  input  logic         cfgStartN,
  input  logic         wrBit,
  input  logic         inWindow,
  output logic [1:0]   mapReg,
  output logic         bankSel,
  output logic         errFlag
);
  logic anyLoad;
  assign anyLoad = strobes.loadCold | strobes.loadWarm | strobes.loadSoft;

  always_ff @(posedge clk) begin
    if (strobes.loadCold)      mapReg <= {1'b0, ~cfgStartN};
    else if (strobes.loadWarm) mapReg <= {mapReg[1], ~cfgStartN};
    else if (strobes.loadSoft) mapReg <= {1'b1, ~cfgStartN};
    else if (strobes.wrBit0)   mapReg[0] <= wrBit;
  end

  always_ff @(posedge clk) begin
    if (anyLoad)             errFlag <= 1'b0;
    else if (strobes.setErr) errFlag <= 1'b1;
  end

  assign bankSel = inWindow & mapReg[0];

  p_cold_load_r1: assert property (@(posedge clk) disable iff (porRst)
    $past(porRst) |-> mapReg == {1'b0, ~$past(cfgStartN)});

  p_warm_keep_r2: assert property (@(posedge clk) disable iff (porRst)
    ($past(strobes.loadWarm) && !$past(porRst))
      |-> mapReg == {$past(mapReg[1]), ~$past(cfgStartN)});

  p_soft_load_r3: assert property (@(posedge clk) disable iff (porRst)
    ($past(strobes.loadSoft) && !$past(porRst)) |-> mapReg == {1'b1, ~$past(cfgStartN)});

  p_write_bit0_r5: assert property (@(posedge clk) disable iff (porRst)
    ($past(strobes.wrBit0) && !$past(porRst))
      |-> (mapReg[0] == $past(wrBit)) && (mapReg[1] == $past(mapReg[1])));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (porRst)
    ($past(errFlag) && !$past(anyLoad) && !$past(porRst)) |-> errFlag);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (porRst)
    ($past(anyLoad) && !$past(porRst)) |-> !errFlag);
endmodule

// File: rtl/prog_bank_ctrl.sv
module prog_bank_ctrl
  import prog_bank_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 13
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              wdtRst,
  input  logic              swRst,
  input  logic              cfgStartN,
  input  logic              wrEn,
  input  logic              wrBit,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [1:0]        mapReg,
  output logic              bankSel,
  output logic              errFlag
);
  ctrlStrobes_t strobes;
  logic         inWindow;

  prog_bank_ctrl_fsm #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_ctrl (
    .porRst(porRst), .wdtRst(wdtRst), .swRst(swRst), .wrEn(wrEn),
    .fetchAddr(fetchAddr), .inWindow(inWindow), .strobes(strobes)
  );

  prog_bank_datapath u_dp (
    .clk(clk), .porRst(porRst), .strobes(strobes), .cfgStartN(cfgStartN),
    .wrBit(wrBit), .inWindow(inWindow), .mapReg(mapReg), .bankSel(bankSel),
    .errFlag(errFlag)
  );

  // R7: outside the window no fetch may be steered to the alternate block
  p_no_remap_high_r7: assert property (@(posedge clk) disable iff (porRst)
    (fetchAddr >= ADDR_W'(1 << WIN_LOG2)) |-> !bankSel);
endmodule

// File: tb/sim_prog_bank_ctrl.sv
module sim_prog_bank_ctrl;
  logic        clk = 1'b0;
  logic        porRst = 1'b1, wdtRst = 1'b0, swRst = 1'b0;
  logic        cfgStartN = 1'b1, wrEn = 1'b0, wrBit = 1'b0;
  logic [15:0] fetchAddr = 16'h0000;
  logic [1:0]  mapReg;
  logic        bankSel, errFlag;

  always #10 clk = ~clk;  // 50 MHz

  prog_bank_ctrl u0 (
    .clk(clk), .porRst(porRst), .wdtRst(wdtRst), .swRst(swRst),
    .cfgStartN(cfgStartN), .wrEn(wrEn), .wrBit(wrBit), .fetchAddr(fetchAddr),
    .mapReg(mapReg), .bankSel(bankSel), .errFlag(errFlag)
  );

  typedef struct {
    logic [1:0] reg_e;
    logic       sel_e;
    logic       err_e;
    string      tag;
  } expItem_t;

  expItem_t   q[$];
  int         nChecks = 0, nFail = 0;
  logic [1:0] mReg = 2'b00;
  logic       mErr = 1'b0;
  bit         done = 1'b0;

  task automatic step(input logic por, input logic wdt, input logic sw,
                      input logic cfg, input logic we, input logic wb,
                      input logic [15:0] addr, input string tag);
    expItem_t it;
    @(negedge clk);
    porRst = por; wdtRst = wdt; swRst = sw; cfgStartN = cfg;
    wrEn = we; wrBit = wb; fetchAddr = addr;
    if (por) begin mReg = {1'b0, ~cfg}; mErr = 1'b0; end
    else if (wdt) begin mReg = {mReg[1], ~cfg}; mErr = 1'b0; end
    else if (sw) begin mReg = {1'b1, ~cfg}; mErr = 1'b0; end
    else if (we) begin
      mReg[0] = wb;
      if (addr < 16'h2000) mErr = 1'b1;
    end
    it.reg_e = mReg;
    it.sel_e = (addr < 16'h2000) ? mReg[0] : 1'b0;
    it.err_e = mErr;
    it.tag   = tag;
    q.push_back(it);
  endtask

  // Monitor: compares after each edge, inputs held until the next negedge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        expItem_t it;
        it = q.pop_front();
        nChecks++;
        if (mapReg !== it.reg_e || bankSel !== it.sel_e || errFlag !== it.err_e) begin
          nFail++;
          $display("FAIL %s: got reg=%b sel=%b err=%b expected reg=%b sel=%b err=%b",
                   it.tag, mapReg, bankSel, errFlag, it.reg_e, it.sel_e, it.err_e);
        end
      end
    end
  end

  initial begin
    step(1,0,0,1,0,0,16'h0100, "R1 cold unprogrammed");
    step(1,0,0,0,0,0,16'h0100, "R1 cold programmed");
    step(0,0,0,0,1,0,16'h4000, "R5 R9 write 0 outside window");
    step(0,0,0,0,0,0,16'h0100, "R6 low window bank 0");
    step(0,0,0,0,1,1,16'h3000, "R5 R9 write 1 outside window");
    step(0,0,0,0,0,0,16'h2000, "R7 boundary 2000h");
    step(0,0,0,0,0,0,16'h1FFF, "R6 boundary 1FFFh");
    step(0,0,0,0,0,0,16'hFFFF, "R7 top address");
    step(0,0,1,1,0,0,16'h0000, "R3 software reset");
    step(0,0,0,1,1,1,16'h1000, "R8 R5 write inside window");
    step(0,0,0,1,0,0,16'h5000, "R8 flag sticky");
    step(0,0,0,0,0,0,16'h0000, "R11 cfg change ignored");
    step(0,1,0,0,0,0,16'h0000, "R2 R10 watchdog keeps bit1");
    step(0,1,0,1,0,0,16'h0000, "R2 watchdog cfg unprogrammed");
    step(0,0,0,1,1,0,16'h0800, "R8 set flag again");
    step(1,1,1,1,0,0,16'h0000, "R4 R10 all causes, cold wins");
    step(0,1,1,0,0,0,16'h0000, "R4 watchdog over software");
    step(0,0,1,0,0,0,16'h1000, "R3 software reset programmed");
    step(0,1,0,1,0,0,16'h1000, "R2 watchdog keeps bit1 set");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule